// File: doc/BRIEF.md
# DMA Event Queue Dispatcher

This block gathers trigger events for 64 event-driven DMA channels and 8 quick-DMA channels and keeps one pending flag per channel. A DMA channel fires from a dedicated external event line, from a chained-transfer completion line, or from a configuration write that sets event bits. A quick channel fires when software writes the trigger word of the parameter set that channel is mapped to. The mapping of quick channels to parameter sets can be changed at run time.

Every cycle the dispatcher takes at most one pending channel and appends its number to one of two 16-entry event queues. A per-channel queue-select bit chooses the queue. A queue-priority bit decides which queue's channels are looked at first. Within a queue, the lowest channel number wins. Each queue head is presented to a transfer-controller port with a valid/ready handshake. Each queue keeps a high-water mark of its occupancy. A missed-event record flags any channel that was triggered again while still pending.

Top module: `dma_evt_dispatch`

Channel numbers: DMA channel k is number k (0..63). Quick channel j is number 64+j (64..71). Configuration writes use `cfg_we`, `cfg_addr` and `cfg_wdata`, and take effect at the clock edge on which `cfg_we` is high.

## Requirements
- R1: After reset the following hold: no channel pending, no missed flags, both queues empty, both high-water marks 0, every queue-select bit 0, queue priority 0, and quick channel j mapped to parameter set j.
- R2: An external event, a chain event, or a write to address 3 (bits for channels 0..31) or address 4 (bits for channels 32..63) with a 1 in a channel's bit sets that channel's `evt_pending` bit at the same edge.
- R3: Address 10 maps quick channel `cfg_wdata[10:8]` to parameter set `cfg_wdata[6:0]`. A cycle with `pset_wr` high triggers every quick channel whose mapped set equals `pset_idx`.
- R4: At most one pending channel is queued per edge, and its pending bit clears. Channels of the priority queue (address 8, bit 0 = queue index) are tried first. Within the chosen queue, the lowest channel number wins.
- R5: Queue-select bits are written at address 0 (channels 0..31), address 1 (channels 32..63) and address 2 (bits 7:0, quick channels). A bit of 1 sends the channel to queue 1; a bit of 0 sends it to queue 0.
- R6: Each queue presents its entries in arrival order. `tcN_valid` is high while the queue is non-empty. An entry leaves on an edge with valid and ready both high. `qN_level` gives the occupancy.
- R7: A queue holds 16 entries. While its queue is full, a channel is not queued and stays pending; no event is lost.
- R8: `qN_wmark` holds the highest occupancy reached since reset. Writing address 9 with bit N set loads it with the occupancy that results at that edge.
- R9: An event on a channel whose pending bit is already set sets its `evt_missed` bit. `err_irq` is high while any missed bit is set. Writes to address 5, 6 or 7 (same bit layout as addresses 3, 4 and 2) clear missed bits, but a new miss in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | 64 | External event per DMA channel, one per high cycle |
| chain_evt | input | 64 | Chained-completion event per DMA channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pset_wr | input | 1 | Trigger word of a parameter set written |
| pset_idx | input | 7 | Parameter set being written |
| tc0_valid | output | 1 | Queue 0 head valid |
| tc0_chan | output | 7 | Queue 0 head channel number |
| tc0_ready | input | 1 | Transfer controller 0 takes the head |
| tc1_valid | output | 1 | Queue 1 head valid |
| tc1_chan | output | 7 | Queue 1 head channel number |
| tc1_ready | input | 1 | Transfer controller 1 takes the head |
| evt_pending | output | 72 | Pending flag per channel |
| evt_missed | output | 72 | Missed-event flag per channel |
| q0_level | output | 5 | Queue 0 occupancy |
| q1_level | output | 5 | Queue 1 occupancy |
| q0_wmark | output | 5 | Queue 0 high-water mark |
| q1_wmark | output | 5 | Queue 1 high-water mark |
| err_irq | output | 1 | Missed-event interrupt |

## Verification
The bench fires all 64 external lines at once while the consumer stalls. A design that drops events at a full queue would show fewer than 48 channels still pending. A design that overwrites a queue entry would break the arrival order.

The bench also flips the queue priority with events pending on both queues. A design that ignores the priority bit would hand the lower-numbered channel of the wrong queue out first. The bench remaps a quick channel and writes a parameter set: a stale mapping would raise the wrong pending bit.

Finally, the bench retriggers pending channels, clears the high-water mark while a queue is partly full, and, under random stimulus, writes a missed-clear in the same cycle as a new miss. Any of these exposes a miss that is lost or a mark that resets to zero instead of to the current occupancy.

// File: rtl/dqd_pkg.sv
package dqd_pkg;

  typedef enum logic [3:0] {
    RG_QSEL_LO = 4'd0,
    RG_QSEL_HI = 4'd1,
    RG_QSEL_QK = 4'd2,
    RG_EVSET_LO = 4'd3,
    RG_EVSET_HI = 4'd4,
    RG_MCLR_LO = 4'd5,
    RG_MCLR_HI = 4'd6,
    RG_MCLR_QK = 4'd7,
    RG_QPRIO = 4'd8,
    RG_WMCLR = 4'd9,
    RG_QKMAP = 4'd10
  } reg_sel_e;

  // larger of two occupancy values
  function automatic logic [7:0] occ_max(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int NCH = 72
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] new_evt,
  input  logic [NCH-1:0] sel_clr,
  input  logic [NCH-1:0] miss_clr,
  output logic [NCH-1:0] pending,
  output logic [NCH-1:0] missed,
  output logic           miss_evt
);

  logic [NCH-1:0] miss_hit;

  assign miss_hit = pending & new_evt;
  assign miss_evt = |miss_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      missed  <= '0;
    end else begin
      pending <= (pending & ~sel_clr) | new_evt;
      missed  <= (missed & ~miss_clr) | miss_hit;
    end
  end

  // a pending channel that was not selected never loses its flag
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pending) & ~$past(sel_clr)) & ~pending) == '0)); // R7

  AST_MISS_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (missed != '0)); // R9

endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int NCH = 72,
  parameter int CHW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pending,
  input  logic [NCH-1:0] qsel,
  input  logic [1:0]     q_full,
  input  logic           prio_q,
  output logic           sel_valid,
  output logic [CHW-1:0] sel_idx,
  output logic           sel_q
);

  logic [NCH-1:0] elig0, elig1, elig_hi, elig_lo;
  logic           use_hi;

  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] v);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = CHW'(i);
    end
    return r;
  endfunction

  assign elig0   = pending & ~qsel & {NCH{~q_full[0]}};
  assign elig1   = pending & qsel & {NCH{~q_full[1]}};
  assign elig_hi = prio_q ? elig1 : elig0;
  assign elig_lo = prio_q ? elig0 : elig1;
  assign use_hi  = |elig_hi;

  assign sel_valid = (|elig0) | (|elig1);
  assign sel_q     = use_hi ? prio_q : ~prio_q;
  assign sel_idx   = lowest_set(use_hi ? elig_hi : elig_lo);

  AST_SEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> pending[sel_idx]); // R4

  AST_SEL_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !q_full[sel_q]); // R7

endmodule

// File: rtl/evt_queue.sv
module evt_queue
  import dqd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 7,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          wm_clr,
  output logic          head_valid,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic [LW-1:0] wmark,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] level_nx;

  assign level_nx   = level + LW'(push) - LW'(pop);
  assign head_valid = (level != '0);
  assign head       = mem[rd_ptr];
  assign full       = (level == LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
      wmark  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level_nx;
      wmark <= wm_clr ? level_nx : LW'(occ_max(8'(wmark), 8'(level_nx)));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R7

  AST_WMARK_GE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    wmark >= level); // R8

  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (level == $past(level) - 1'b1)); // R6

  AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid); // R6

endmodule

// File: rtl/dma_evt_dispatch.sv
module dma_evt_dispatch
  import dqd_pkg::*;
#(
  parameter int NDMA  = 64,
  parameter int NQK   = 8,
  parameter int QDEPTH = 16,
  parameter int NPSET = 128,
  localparam int NCH  = NDMA + NQK,
  localparam int CHW  = $clog2(NCH),
  localparam int PSW  = $clog2(NPSET),
  localparam int QKW  = $clog2(NQK),
  localparam int LW   = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDMA-1:0] ext_evt,
  input  logic [NDMA-1:0] chain_evt,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            pset_wr,
  input  logic [PSW-1:0]  pset_idx,
  output logic            tc0_valid,
  output logic [CHW-1:0]  tc0_chan,
  input  logic            tc0_ready,
  output logic            tc1_valid,
  output logic [CHW-1:0]  tc1_chan,
  input  logic            tc1_ready,
  output logic [NCH-1:0]  evt_pending,
  output logic [NCH-1:0]  evt_missed,
  output logic [LW-1:0]   q0_level,
  output logic [LW-1:0]   q1_level,
  output logic [LW-1:0]   q0_wmark,
  output logic [LW-1:0]   q1_wmark,
  output logic            err_irq
);

  // configuration state
  logic [NCH-1:0] qsel;
  logic           prio_q;
  logic [PSW-1:0] qk_map [NQK];

  // named internal events
  logic [NDMA-1:0] evset;
  logic [NCH-1:0]  miss_clr;
  logic [1:0]      wm_clr;
  logic [NQK-1:0]  qk_hit;
  logic [NCH-1:0]  new_evt;
  logic [NCH-1:0]  sel_clr;
  logic            sel_valid;
  logic [CHW-1:0]  sel_idx;
  logic            sel_q;
  logic            miss_evt;
  logic [1:0]      q_push, q_pop, q_valid, q_full, q_ready;
  logic [CHW-1:0]  q_head [2];
  logic [LW-1:0]   q_level [2];
  logic [LW-1:0]   q_wmark [2];

  // configuration write decode
  always_comb begin
    evset    = '0;
    miss_clr = '0;
    wm_clr   = '0;
    if (cfg_we) begin
      case (cfg_addr)
        RG_EVSET_LO: evset[31:0]       = cfg_wdata;
        RG_EVSET_HI: evset[NDMA-1:32]  = cfg_wdata[NDMA-33:0];
        RG_MCLR_LO:  miss_clr[31:0]    = cfg_wdata;
        RG_MCLR_HI:  miss_clr[NDMA-1:32] = cfg_wdata[NDMA-33:0];
        RG_MCLR_QK:  miss_clr[NCH-1:NDMA] = cfg_wdata[NQK-1:0];
        RG_WMCLR:    wm_clr            = cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qsel   <= '0;
      prio_q <= 1'b0;
      for (int j = 0; j < NQK; j++) qk_map[j] <= PSW'(j);
    end else if (cfg_we) begin
      case (cfg_addr)
        RG_QSEL_LO: qsel[31:0]        <= cfg_wdata;
        RG_QSEL_HI: qsel[NDMA-1:32]   <= cfg_wdata[NDMA-33:0];
        RG_QSEL_QK: qsel[NCH-1:NDMA]  <= cfg_wdata[NQK-1:0];
        RG_QPRIO:   prio_q            <= cfg_wdata[0];
        RG_QKMAP:   qk_map[cfg_wdata[8+QKW-1:8]] <= cfg_wdata[PSW-1:0];
        default: ;
      endcase
    end
  end

  // quick channels fire on a write to their mapped parameter set
  for (genvar j = 0; j < NQK; j++) begin : g_qk
    assign qk_hit[j] = pset_wr && (pset_idx == qk_map[j]);
  end

  assign new_evt = {qk_hit, ext_evt | chain_evt | evset};

  always_comb begin
    sel_clr = '0;
    if (sel_valid) sel_clr[sel_idx] = 1'b1;
  end

  evt_capture #(.NCH(NCH)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_evt  (new_evt),
    .sel_clr  (sel_clr),
    .miss_clr (miss_clr),
    .pending  (evt_pending),
    .missed   (evt_missed),
    .miss_evt (miss_evt)
  );

  evt_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (evt_pending),
    .qsel      (qsel),
    .q_full    (q_full),
    .prio_q    (prio_q),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_q     (sel_q)
  );

  assign q_ready = {tc1_ready, tc0_ready};

  for (genvar q = 0; q < 2; q++) begin : g_q
    assign q_push[q] = sel_valid && (sel_q == q[0]);
    assign q_pop[q]  = q_valid[q] && q_ready[q];

    evt_queue #(.DEPTH(QDEPTH), .DW(CHW)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (q_push[q]),
      .din        (sel_idx),
      .pop        (q_pop[q]),
      .wm_clr     (wm_clr[q]),
      .head_valid (q_valid[q]),
      .head       (q_head[q]),
      .level      (q_level[q]),
      .wmark      (q_wmark[q]),
      .full       (q_full[q])
    );
  end

  assign tc0_valid = q_valid[0];
  assign tc1_valid = q_valid[1];
  assign tc0_chan  = q_head[0];
  assign tc1_chan  = q_head[1];
  assign q0_level  = q_level[0];
  assign q1_level  = q_level[1];
  assign q0_wmark  = q_wmark[0];
  assign q1_wmark  = q_wmark[1];
  assign err_irq   = |evt_missed;

  AST_ONE_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_push)); // R4

  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !new_evt[sel_idx]) |=> !evt_pending[$past(sel_idx)]); // R4

  AST_IRQ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> err_irq); // R9

endmodule

// File: tb/sim_dma_evt_dispatch.sv
module sim_dma_evt_dispatch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ext_evt, chain_evt;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pset_wr;
  logic [6:0]  pset_idx;
  logic        tc0_valid, tc1_valid, tc0_ready, tc1_ready;
  logic [6:0]  tc0_chan, tc1_chan;
  logic [71:0] evt_pending, evt_missed;
  logic [4:0]  q0_level, q1_level, q0_wmark, q1_wmark;
  logic        err_irq;

  int n_chk = 0;
  int n_fail = 0;
  int seed_v;

  always #10 clk = ~clk; // 50 MHz

  dma_evt_dispatch u0 (.*);

  // reference state
  bit [71:0] m_pend, m_miss, m_qsel;
  bit        m_prio;
  int        m_qk [8];
  int        mq0[$], mq1[$];
  int        m_wm [2];

  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction

  always @(posedge clk) begin
    bit [71:0] nev, clr;
    int pick, pq, lv;
    if (!rst_n) begin
      m_pend = '0; m_miss = '0; m_qsel = '0; m_prio = 0;
      for (int j = 0; j < 8; j++) m_qk[j] = j;
      mq0.delete(); mq1.delete(); m_wm[0] = 0; m_wm[1] = 0;
    end else begin
      nev = {8'h0, ext_evt | chain_evt};
      clr = '0;
      if (cfg_we && cfg_addr == 3) nev[31:0]  |= cfg_wdata;
      if (cfg_we && cfg_addr == 4) nev[63:32] |= cfg_wdata;
      if (cfg_we && cfg_addr == 5) clr[31:0]  = cfg_wdata;
      if (cfg_we && cfg_addr == 6) clr[63:32] = cfg_wdata;
      if (cfg_we && cfg_addr == 7) clr[71:64] = cfg_wdata[7:0];
      for (int j = 0; j < 8; j++)
        if (pset_wr && m_qk[j] == int'(pset_idx)) nev[64+j] = 1'b1;
      pick = -1; pq = 0;
      for (int pass = 0; pass < 2 && pick < 0; pass++) begin
        int qq;
        qq = (pass == 0) ? int'(m_prio) : int'(!m_prio);
        for (int c = 0; c < 72 && pick < 0; c++)
          if (m_pend[c] && int'(m_qsel[c]) == qq &&
              ((qq == 0) ? mq0.size() : mq1.size()) < 16) begin
            pick = c; pq = qq;
          end
      end
      if (tc0_ready && mq0.size() > 0) void'(mq0.pop_front());
      if (tc1_ready && mq1.size() > 0) void'(mq1.pop_front());
      if (pick >= 0) begin
        if (pq == 0) mq0.push_back(pick); else mq1.push_back(pick);
      end
      for (int q = 0; q < 2; q++) begin
        lv = (q == 0) ? mq0.size() : mq1.size();
        if (cfg_we && cfg_addr == 9 && cfg_wdata[q]) m_wm[q] = lv;
        else m_wm[q] = mx(m_wm[q], lv);
      end
      m_miss = (m_miss & ~clr) | (m_pend & nev);
      if (pick >= 0) m_pend[pick] = 1'b0;
      m_pend |= nev;
      if (cfg_we && cfg_addr == 0) m_qsel[31:0]  = cfg_wdata;
      if (cfg_we && cfg_addr == 1) m_qsel[63:32] = cfg_wdata;
      if (cfg_we && cfg_addr == 2) m_qsel[71:64] = cfg_wdata[7:0];
      if (cfg_we && cfg_addr == 8) m_prio = cfg_wdata[0];
      if (cfg_we && cfg_addr == 10) m_qk[cfg_wdata[10:8]] = int'(cfg_wdata[6:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(evt_pending == m_pend, "R2", "pending[63:0]", evt_pending[63:0], m_pend[63:0]);
    chk(evt_pending[71:64] == m_pend[71:64], "R3", "quick pending", evt_pending[71:64], m_pend[71:64]);
    chk(evt_missed == m_miss, "R9", "missed[63:0]", evt_missed[63:0], m_miss[63:0]);
    chk(err_irq == (m_miss != 0), "R9", "err_irq", err_irq, m_miss != 0);
    chk(q0_level == mq0.size() && q1_level == mq1.size(), "R6", "levels",
        {q1_level, q0_level}, {5'(mq1.size()), 5'(mq0.size())});
    chk(q0_wmark == m_wm[0] && q1_wmark == m_wm[1], "R8", "wmarks",
        {q1_wmark, q0_wmark}, {5'(m_wm[1]), 5'(m_wm[0])});
    chk(tc0_valid == (mq0.size() > 0) && (!tc0_valid || tc0_chan == mq0[0]),
        "R4", "tc0 head", {tc0_valid, tc0_chan}, (mq0.size() > 0) ? {1'b1, 7'(mq0[0])} : 8'h0);
    chk(tc1_valid == (mq1.size() > 0) && (!tc1_valid || tc1_chan == mq1[0]),
        "R5", "tc1 head", {tc1_valid, tc1_chan}, (mq1.size() > 0) ? {1'b1, 7'(mq1[0])} : 8'h0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    ext_evt = '0; chain_evt = '0; cfg_we = 0; pset_wr = 0;
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    step();
  endtask

  initial begin
    rst_n = 0; ext_evt = '0; chain_evt = '0; cfg_we = 0; cfg_addr = '0;
    cfg_wdata = '0; pset_wr = 0; pset_idx = '0; tc0_ready = 0; tc1_ready = 0;
    seed_v = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(evt_pending == 0 && evt_missed == 0 && !err_irq, "R1", "flags", evt_pending[63:0], 0);
    chk(!tc0_valid && !tc1_valid && q0_level == 0 && q1_wmark == 0, "R1", "queues",
        {tc0_valid, tc1_valid, q0_level}, 0);

    // R7 full queue stalls, nothing dropped
    ext_evt = '1; step();
    repeat (20) step();
    chk(q0_level == 16, "R7", "q0 full level", q0_level, 16);
    chk($countones(evt_pending) == 48, "R7", "still pending", $countones(evt_pending), 48);
    chk(tc0_chan == 0, "R6", "first in order", tc0_chan, 0);
    tc0_ready = 1;
    repeat (70) step();
    chk(evt_pending == 0 && q0_level == 0, "R7", "drained", q0_level, 0);
    chk(q0_wmark == 16, "R8", "wmark kept", q0_wmark, 16);
    tc0_ready = 0;

    // R5 / R4 queue priority
    cfg(0, 32'h0000_0020);          // channel 5 -> queue 1
    cfg(8, 32'h1);                  // queue 1 first
    ext_evt[2] = 1; ext_evt[5] = 1; step();
    step();
    chk(tc1_valid && tc1_chan == 5 && !tc0_valid, "R4", "priority queue first",
        {tc1_valid, tc1_chan}, {1'b1, 7'd5});
    step();
    chk(tc0_valid && tc0_chan == 2, "R5", "queue 0 path", tc0_chan, 2);

    // R8 clear loads current occupancy
    cfg(9, 32'h3);
    chk(q0_wmark == 1 && q1_wmark == 1, "R8", "wm clear", {q1_wmark, q0_wmark}, {5'd1, 5'd1});
    tc0_ready = 1; tc1_ready = 1; repeat (3) step();

    // R3 quick-channel remap
    cfg(10, {21'h0, 3'd3, 1'b0, 7'd40});
    tc0_ready = 0;
    pset_wr = 1; pset_idx = 7'd40; step();
    chk(evt_pending[67] && $countones(evt_pending) == 1, "R3", "quick 3 fired",
        evt_pending[71:64], 8'h08);

    // R9 retrigger while pending
    ext_evt[10] = 1; step();
    ext_evt[10] = 1; step();
    chk(evt_missed[10] && err_irq, "R9", "miss set", evt_missed[10], 1);
    cfg(5, 32'h0000_0400);
    chk(!evt_missed[10], "R9", "miss cleared", evt_missed[10], 0);

    // R2 event-set write
    cfg(4, 32'h8000_0001);
    chk(evt_pending[32] && evt_pending[63], "R2", "event set write", evt_pending[63:32], 64'h8000_0001);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      ext_evt   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      chain_evt = ($urandom_range(0, 7) == 0) ? 64'(1) << $urandom_range(0, 63) : 64'h0;
      pset_wr   = ($urandom_range(0, 5) == 0);
      pset_idx  = 7'($urandom_range(0, 12));
      tc0_ready = ($urandom_range(0, 3) != 0);
      tc1_ready = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; cfg_addr = 4'($urandom_range(0, 10)); cfg_wdata = $urandom;
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule